// File: doc/BRIEF.md
# Two-Wire Debug Link Frame Master

This block is the host end of a two-wire debug link. It drives a strobe clock toward the target. A single data line runs in both directions, and the block controls it through an output value, an output enable and an input. A user issues one request. The request gives an operation code and, for write frames, an address or data byte. The block then plays out the complete frame on the wire. When the frame is over, it returns a one-cycle completion pulse with a result byte and an error flag.

There are five operations. Four are single-byte frames: write the target's address register, read the address register, write the target's data register and read the data register. The fifth is a link reset, which holds the clock low for a long time. Every bit on the wire is a short low pulse on the clock. All pulse widths are whole multiples of a clocks-per-microsecond parameter. Data frames include a wait field, in which the target signals that it is ready by pulling the line high. The block makes a bounded number of attempts there and reports a timeout as an error.

Top module: `dbg2w_master`

## Requirements
- R1: After reset the clock output is high, the data line is released (`sd_oe_o`=0), `done_o` and `busy_o` are low.
- R2: Every bit strobe holds the clock low for exactly STB_LOW_US×CLKS_PER_US system clocks, which stays below 5 µs. It is followed by at least STB_HIGH_US×CLKS_PER_US clocks high.
- R3: Operation code 4 (link reset) produces a single low pulse of exactly RST_LOW_US×CLKS_PER_US clocks with the line released. It then completes with `err_o`=0 and `rdata_o`=0.
- R4: Every frame opens with one strobe while the line is released. Two driven instruction strobes follow, first bit first: 1,1 for address write (code 0), 0,1 for address read (code 1), 1,0 for data write (code 2), 0,0 for data read (code 3).
- R5: An address write drives `wdata_i` bit 0 first over 8 strobes. It then releases the line for one closing strobe, 12 strobes in all.
- R6: An address read releases the line for 8 strobes and samples `sd_i` at the end of each strobe. The first sample becomes bit 0 of `rdata_o`. One closing strobe follows, 12 strobes in all.
- R7: Data write and data read drive two length strobes of value 0,0 directly after the instruction.
- R8: A data write drives `wdata_i` bit 0 first over 8 strobes and then enters the wait field with the line released. A data read enters the wait field right after the length field, then samples 8 bits first-bit-to-bit-0 into `rdata_o`.
- R9: The wait field strobes and samples until `sd_i` is seen high, for at most WAIT_TRIES attempts. High on attempt n (n ≤ WAIT_TRIES) continues the frame and ends with one closing strobe. If `sd_i` is never high, the frame ends after the last attempt with `err_o`=1, no closing strobe and `rdata_o`=0.
- R10: `done_o` is a one-cycle pulse, and `busy_o` is high from acceptance until that pulse. Requests arriving while busy are ignored. Write frames return `rdata_o`=0. The line is driven only while busy.
- R11: Operation codes 5 to 7 complete in the cycle after the request with `err_o`=1, without any clock activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken only when idle |
| op_i | input | 3 | Operation code (0..4 valid) |
| wdata_i | input | 8 | Address or data byte for write frames |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A frame or reset pulse is in progress |
| rdata_o | output | 8 | Byte read by the last frame |
| err_o | output | 1 | Last request timed out or was invalid |
| sck_o | output | 1 | Strobe clock to the target |
| sd_o | output | 1 | Data line value when driven |
| sd_oe_o | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line as seen by the master |

## Verification
The bench goes after the edges of the wait field: the target answers on attempt 1, on the last permitted attempt, or never. A design with an off-by-one attempt counter would time out one strobe early, or add an extra strobe that shifts the data field. It also checks bit order and the instruction pairs strobe by strobe, where a swapped pair or MSB-first shifting would show up as a wrong driven bit or a mirrored read byte. Stray requests during a frame, invalid operation codes and the long reset pulse are covered too, since a design that restarts on a second request, or times every low pulse the same way, would corrupt the strobe log or the pulse widths.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;
  typedef enum logic [2:0] {
    OP_ADDR_WR  = 3'd0,
    OP_ADDR_RD  = 3'd1,
    OP_DATA_WR  = 3'd2,
    OP_DATA_RD  = 3'd3,
    OP_LINK_RST = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_START, S_INS, S_LEN, S_SHOUT, S_SHIN, S_WAIT, S_STOP
  } st_e;

  // instruction pair, bit 0 goes on the wire first
  function automatic logic [1:0] ins_bits(op_e op);
    case (op)
      OP_ADDR_WR: ins_bits = 2'b11;
      OP_ADDR_RD: ins_bits = 2'b10;
      OP_DATA_WR: ins_bits = 2'b01;
      default:    ins_bits = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/dbg2w_strobe.sv
module dbg2w_strobe #(
  parameter int CLKS_PER_US = 8,
  parameter int LOW_US      = 1,
  parameter int HIGH_US     = 1,
  parameter int RST_LOW_US  = 25,
  parameter int RST_HIGH_US = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic long_i,
  output logic sck_o,
  output logic done_o
);
  localparam int LowClks  = LOW_US * CLKS_PER_US;
  localparam int HighClks = HIGH_US * CLKS_PER_US;
  localparam int RLowClks = RST_LOW_US * CLKS_PER_US;
  localparam int RHiClks  = RST_HIGH_US * CLKS_PER_US;
  localparam int MaxA     = (LowClks > HighClks) ? LowClks : HighClks;
  localparam int MaxB     = (RLowClks > RHiClks) ? RLowClks : RHiClks;
  localparam int MaxClks  = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int CW       = $clog2(MaxClks + 1);

  typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} ph_e;

  ph_e           ph_q;
  logic [CW-1:0] cnt_q;
  logic          long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= P_IDLE;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      unique case (ph_q)
        P_IDLE: if (go_i) begin
          ph_q   <= P_LOW;
          long_q <= long_i;
          cnt_q  <= long_i ? CW'(RLowClks - 1) : CW'(LowClks - 1);
        end
        P_LOW: if (cnt_q == '0) begin
          ph_q  <= P_HIGH;
          cnt_q <= long_q ? CW'(RHiClks - 1) : CW'(HighClks - 1);
        end else cnt_q <= cnt_q - 1'b1;
        P_HIGH: if (cnt_q == '0) ph_q <= P_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  assign sck_o  = (ph_q != P_LOW);
  assign done_o = (ph_q == P_HIGH) && (cnt_q == '0);
endmodule

// File: rtl/dbg2w_seq.sv
module dbg2w_seq
  import dbg2w_pkg::*;
#(
  parameter int WAIT_TRIES = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [2:0] op_i,
  input  logic [7:0] wdata_i,
  input  logic       stb_done_i,
  input  logic       sd_i,
  output logic       stb_go_o,
  output logic       stb_long_o,
  output logic       sd_o,
  output logic       sd_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       err_o
);
  localparam int TW = $clog2(WAIT_TRIES + 1);

  st_e           st_q;
  op_e           op_q;
  logic [7:0]    sh_q, rdata_q;
  logic [2:0]    bit_q;
  logic [TW-1:0] try_q;
  logic          wait_q, go_q, sd_q, oe_q, done_q, err_q;
  logic [1:0]    ins;

  assign ins = ins_bits(op_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;   op_q <= OP_ADDR_WR;
      sh_q <= '0;       rdata_q <= '0;
      bit_q <= '0;      try_q <= '0;
      wait_q <= 1'b0;   go_q <= 1'b0;
      sd_q <= 1'b0;     oe_q <= 1'b0;
      done_q <= 1'b0;   err_q <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (req_i) begin
          if (op_i > 3'd4) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else begin
            op_q  <= op_e'(op_i);
            st_q  <= (op_i == OP_LINK_RST) ? S_RST : S_START;
            sh_q  <= (op_i == OP_ADDR_WR || op_i == OP_DATA_WR) ? wdata_i : 8'h00;
            bit_q <= '0;
            try_q <= '0;
            oe_q  <= 1'b0;
            sd_q  <= 1'b0;
          end
        end
      end else if (!wait_q) begin
        go_q   <= 1'b1;   // line already set up before the falling edge
        wait_q <= 1'b1;
      end else if (stb_done_i) begin
        wait_q <= 1'b0;
        unique case (st_q)
          S_RST, S_STOP: begin
            st_q    <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b0;
            rdata_q <= sh_q;
          end
          S_START: begin
            oe_q  <= 1'b1;
            sd_q  <= ins[0];
            st_q  <= S_INS;
            bit_q <= '0;
          end
          S_INS: if (bit_q == 3'd0) begin
            sd_q  <= ins[1];
            bit_q <= 3'd1;
          end else begin
            bit_q <= '0;
            case (op_q)
              OP_ADDR_WR: begin st_q <= S_SHOUT; sd_q <= sh_q[0]; end
              OP_ADDR_RD: begin st_q <= S_SHIN;  oe_q <= 1'b0;    end
              default:    begin st_q <= S_LEN;   sd_q <= 1'b0;    end
            endcase
          end
          S_LEN: if (bit_q == 3'd0) bit_q <= 3'd1;
          else begin
            bit_q <= '0;
            if (op_q == OP_DATA_WR) begin
              st_q <= S_SHOUT;
              sd_q <= sh_q[0];
            end else begin
              st_q <= S_WAIT;
              oe_q <= 1'b0;
            end
          end
          S_SHOUT: begin
            sh_q <= {1'b0, sh_q[7:1]};
            sd_q <= sh_q[1];
            if (bit_q == 3'd7) begin
              oe_q  <= 1'b0;
              bit_q <= '0;
              st_q  <= (op_q == OP_ADDR_WR) ? S_STOP : S_WAIT;
            end else bit_q <= bit_q + 1'b1;
          end
          S_SHIN: begin
            sh_q <= {sd_i, sh_q[7:1]};
            if (bit_q == 3'd7) st_q <= S_STOP;
            else bit_q <= bit_q + 1'b1;
          end
          S_WAIT: if (sd_i) begin
            bit_q <= '0;
            st_q  <= (op_q == OP_DATA_RD) ? S_SHIN : S_STOP;
          end else if (try_q == TW'(WAIT_TRIES - 1)) begin
            st_q    <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else try_q <= try_q + 1'b1;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign stb_go_o   = go_q;
  assign stb_long_o = (st_q == S_RST);
  assign sd_o       = sd_q;
  assign sd_oe_o    = oe_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign err_o      = err_q;
endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master #(
  parameter int CLKS_PER_US = 8,
  parameter int WAIT_TRIES  = 20,
  parameter int STB_LOW_US  = 1,
  parameter int STB_HIGH_US = 1,
  parameter int RST_LOW_US  = 25,
  parameter int RST_HIGH_US = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [2:0] op_i,
  input  logic [7:0] wdata_i,
  output logic       done_o,
  output logic       busy_o,
  output logic [7:0] rdata_o,
  output logic       err_o,
  output logic       sck_o,
  output logic       sd_o,
  output logic       sd_oe_o,
  input  logic       sd_i
);
  logic stb_go, stb_long, stb_done;

  dbg2w_seq #(.WAIT_TRIES(WAIT_TRIES)) u_seq (
    .clk_i, .rst_ni, .req_i, .op_i, .wdata_i,
    .stb_done_i(stb_done), .sd_i,
    .stb_go_o(stb_go), .stb_long_o(stb_long),
    .sd_o, .sd_oe_o, .busy_o, .done_o, .rdata_o, .err_o
  );

  dbg2w_strobe #(
    .CLKS_PER_US(CLKS_PER_US), .LOW_US(STB_LOW_US), .HIGH_US(STB_HIGH_US),
    .RST_LOW_US(RST_LOW_US), .RST_HIGH_US(RST_HIGH_US)
  ) u_stb (
    .clk_i, .rst_ni, .go_i(stb_go), .long_i(stb_long),
    .sck_o, .done_o(stb_done)
  );
endmodule

// File: rtl/dbg2w_master_chk.sv
module dbg2w_master_chk #(
  parameter int CLKS_PER_US = 8,
  parameter int STB_LOW_US  = 1,
  parameter int RST_LOW_US  = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_i,
  input logic long_i,
  input logic sd_oe_i,
  input logic busy_i,
  input logic done_i
);
  localparam int StbLow = STB_LOW_US * CLKS_PER_US;
  localparam int RstLow = RST_LOW_US * CLKS_PER_US;
  localparam int LW     = $clog2(RstLow + 2) + 1;

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt <= '0;
    else if (!sck_i) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (sck_i && !sd_oe_i));

  a_r2_strobe_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_i && !long_i) |-> (int'(low_cnt) < StbLow));

  a_r3_reset_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_i |-> (int'(low_cnt) < RstLow));

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r10_drive_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_i |-> busy_i);
endmodule

bind dbg2w_master dbg2w_master_chk #(
  .CLKS_PER_US(CLKS_PER_US), .STB_LOW_US(STB_LOW_US), .RST_LOW_US(RST_LOW_US)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_o), .long_i(stb_long),
  .sd_oe_i(sd_oe_o), .busy_i(busy_o), .done_i(done_o)
);

// File: tb/dbg2w_master_bench.sv
`timescale 1ns/1ps
module dbg2w_master_bench;
  localparam int CPU = 4;
  localparam int TRIES = 20;
  localparam int SL = CPU;       // strobe low clocks
  localparam int RL = 25 * CPU;  // reset low clocks

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] wd = '0;
  logic done, busy, err, sck, sd, sd_oe;
  logic [7:0] rdata;
  logic sd_in = 1'b0;

  always #2.5 clk = ~clk;

  dbg2w_master #(.CLKS_PER_US(CPU), .WAIT_TRIES(TRIES)) u_dbg2w_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .wdata_i(wd),
    .done_o(done), .busy_o(busy), .rdata_o(rdata), .err_o(err),
    .sck_o(sck), .sd_o(sd), .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  int nchk = 0, nerr = 0;
  logic resp [64];
  logic log_oe [64], log_sd [64];
  logic e_oe [64], e_sd [64];
  int nfall = 0, low_cur = 0, nlow = 0, bad_w = 0, exp_low = SL, ndone = 0;

  // target model: log line at each falling edge, answer for that strobe
  always @(negedge sck) begin
    if (nfall < 64) begin
      log_oe[nfall] = sd_oe;
      log_sd[nfall] = sd;
      sd_in = resp[nfall];
    end
    nfall++;
  end

  always @(negedge clk) begin
    if (done) ndone++;
    if (!sck) low_cur++;
    else if (low_cur > 0) begin
      nlow++;
      if (low_cur != exp_low) bad_w++;
      low_cur = 0;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, expv);
    end
  endtask

  task automatic run_frame(input int opc, input logic [7:0] wb, input int w,
                           input logic [7:0] rb, input bit stray, input string tag);
    int e_n, t, mism, d0;
    logic [7:0] e_rd;
    logic e_err;
    for (int i = 0; i < 64; i++) begin resp[i] = 1'b0; e_oe[i] = 1'b0; e_sd[i] = 1'b0; end
    e_rd = 8'h00; e_err = 1'b0; e_n = 0;
    exp_low = (opc == 4) ? RL : SL;
    case (opc)
      0: begin
        e_n = 12;
        e_oe[1] = 1; e_sd[1] = 1; e_oe[2] = 1; e_sd[2] = 1;
        for (int i = 0; i < 8; i++) begin e_oe[3+i] = 1; e_sd[3+i] = wb[i]; end
      end
      1: begin
        e_n = 12; e_rd = rb;
        e_oe[1] = 1; e_sd[1] = 0; e_oe[2] = 1; e_sd[2] = 1;
        for (int i = 0; i < 8; i++) resp[3+i] = rb[i];
      end
      2: begin
        e_oe[1] = 1; e_sd[1] = 1; e_oe[2] = 1; e_sd[2] = 0;
        e_oe[3] = 1; e_oe[4] = 1;
        for (int i = 0; i < 8; i++) begin e_oe[5+i] = 1; e_sd[5+i] = wb[i]; end
        if (w <= TRIES) begin resp[12+w] = 1; e_n = 14 + w; end
        else begin e_n = 13 + TRIES; e_err = 1; end
      end
      3: begin
        e_oe[1] = 1; e_oe[2] = 1; e_oe[3] = 1; e_oe[4] = 1;
        if (w <= TRIES) begin
          resp[4+w] = 1; e_rd = rb; e_n = 14 + w;
          for (int i = 0; i < 8; i++) resp[5+w+i] = rb[i];
        end else begin e_n = 5 + TRIES; e_err = 1; end
      end
      4: e_n = 1;
      default: begin e_n = 0; e_err = 1; end
    endcase
    nfall = 0; nlow = 0; bad_w = 0; d0 = ndone;
    @(negedge clk); req = 1'b1; op = 3'(opc); wd = wb;
    @(negedge clk); req = 1'b0; op = 3'(($urandom % 5)); wd = 8'($urandom);
    if (opc <= 4) chk(busy === 1'b1, "R10", "busy after accept", int'(busy), 1);
    else chk(done === 1'b1 && busy === 1'b0, "R11", "invalid op immediate done", int'(done), 1);
    if (stray) begin
      repeat (10) @(negedge clk);
      req = 1'b1; op = 3'((opc + 1) % 5); wd = ~wb;
      @(negedge clk); req = 1'b0;
    end
    t = 0;
    while (done !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, tag, "frame completion", t, 0);
    chk(err === e_err, (opc > 4) ? "R11" : (e_err ? "R9" : tag), "err_o", int'(err), int'(e_err));
    chk(rdata === e_rd, (opc == 1) ? "R6" : (opc == 3) ? "R8" : "R10", "rdata_o", int'(rdata), int'(e_rd));
    chk(nfall == e_n, (e_err && opc <= 4) ? "R9" : tag, "strobe count", nfall, e_n);
    mism = 0;
    for (int i = 0; i < e_n && i < 64; i++)
      if (log_oe[i] !== e_oe[i] || (e_oe[i] && log_sd[i] !== e_sd[i])) mism++;
    chk(mism == 0, (opc == 0) ? "R4" : (opc >= 2 && opc <= 3) ? "R7" : tag,
        "line pattern mismatches", mism, 0);
    chk(bad_w == 0 && nlow == e_n, (opc == 4) ? "R3" : "R2", "low pulse widths", bad_w, 0);
    repeat (3) @(negedge clk);
    chk(ndone - d0 == 1 && busy === 1'b0, "R10", "single done then idle", ndone - d0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    for (int i = 0; i < 64; i++) resp[i] = 1'b0;
    repeat (4) @(negedge clk);
    chk(sck === 1'b1 && sd_oe === 1'b0 && done === 1'b0 && busy === 1'b0,
        "R1", "reset state", int'({sck, sd_oe, done, busy}), 8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck === 1'b1 && sd_oe === 1'b0, "R1", "idle after reset", int'({sck, sd_oe}), 2);

    run_frame(0, 8'hB4, 1, 8'h00, 0, "R5");
    run_frame(1, 8'h00, 1, 8'hA5, 0, "R6");
    run_frame(1, 8'h00, 1, 8'h01, 0, "R6");
    run_frame(2, 8'h3C, 1, 8'h00, 0, "R8");
    run_frame(2, 8'hC1, TRIES, 8'h00, 0, "R9");
    run_frame(2, 8'h5A, TRIES + 1, 8'h00, 0, "R9");
    run_frame(3, 8'h00, 1, 8'h81, 0, "R8");
    run_frame(3, 8'h00, TRIES, 8'h7E, 0, "R9");
    run_frame(3, 8'h00, TRIES + 1, 8'hFF, 0, "R9");
    run_frame(4, 8'h00, 1, 8'h00, 0, "R3");
    run_frame(5, 8'h00, 1, 8'h00, 0, "R11");
    run_frame(7, 8'h00, 1, 8'h00, 0, "R11");
    run_frame(0, 8'h69, 1, 8'h00, 1, "R10");
    run_frame(3, 8'h00, 3, 8'h96, 1, "R10");

    for (int k = 0; k < 40; k++)
      run_frame(int'($urandom % 5), 8'($urandom), 1 + int'($urandom % (TRIES + 1)),
                8'($urandom), bit'($urandom % 4 == 0), "R8");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule